// File: doc/BRIEF.md
# VLIW Deferred Write Commit Queue

This block holds the architectural writes that the instructions of one VLIW packet produce, so that they all take effect together once the packet has finished. Each queued write is one of three kinds: a register data write, a direct PC write, or a PC write whose target was computed by a function. Each entry also records the register target, the value, the address of the instruction that issued it, and a force flag. At the start of a packet the issuing pipeline pulses `pkt_start` to empty the queue. It then pushes writes with `enq_valid`. When the packet is done it pulses `commit_start` together with the address of the next sequential packet (`seq_pc`).

The commit sequencer replays the queued entries in the order they were pushed, one entry per clock. Register writes appear on the write port. The visible PC (`pc_out`) follows the issuing address of each entry that executes. Only the first PC write that executes is kept. If an imprecise exception is pending, entries issued by the excepting instruction are filtered. For a floating-point exception they survive only when every cause bit is one of the benign ones. For any other exception they survive only when they carry the force flag. After the last entry, `pc_out` takes the kept branch target, or `seq_pc` when no branch survived. A pending link request writes `seq_pc` to the link register. The queue is then emptied and `commit_done` pulses.

Top module: `vliw_commit_queue`

## Requirements
- R1: After reset, `commit_busy`, `commit_done`, `wr_en`, `lr_wr_en` and `enq_overflow` are 0, `pc_out` is 0, and the queue is empty.
- R2: A commit outputs every executed register entry in push order, one per clock. During an entry's cycle, `wr_en`=1 with its target and value, and `pc_out` equals its issuing address. Kind codes are 0 (register), 1 (direct PC), 2 (function PC) and 3 (treated as register).
- R3: An enqueue while the queue already holds DEPTH entries is dropped, and `enq_overflow` is 1 for exactly the cycle after it. All other enqueues leave it 0.
- R4: `pkt_start` empties the queue, so a following commit produces no register writes and leaves `pc_out` at `seq_pc`.
- R5: Among the executed entries, only the first one of kind 1 or 2 takes effect. After the commit, `pc_out` equals that entry's value, and later PC entries are ignored.
- R6: When no PC entry executes, `pc_out` equals the `seq_pc` sampled with `commit_start` after the commit.
- R7: Exception filtering only affects entries whose issuing address equals `exc_iaddr` while `exc_pending` is 1. All other entries always execute.
- R8: With `exc_is_fp`=1, a matching entry is skipped when `exc_fp_mask` has any bit set outside bits [2:0] (the inexact, underflow and overflow causes). Otherwise it executes.
- R9: With `exc_is_fp`=0, a matching entry executes only if its force flag is 1.
- R10: A `lr_req` pulse before a commit makes that commit assert `lr_wr_en` with `lr_value`=`seq_pc` in its `commit_done` cycle. The request is then consumed, so the next commit without a new request writes no link value.
- R11: `commit_done` is a one-cycle pulse, issued N+2 clocks after `commit_start` for N queued entries. The queue is empty in that cycle.
- R12: A PC entry skipped by the exception filter does not count as the first branch, so a later executed PC entry still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | Empty the queue at the start of a packet |
| enq_valid | input | 1 | Push one write (ignored while committing) |
| enq_kind | input | 2 | Write kind code |
| enq_target | input | TGT_W | Register target |
| enq_value | input | DATA_W | Write value or branch target |
| enq_iaddr | input | ADDR_W | Issuing instruction address |
| enq_force | input | 1 | Force flag |
| enq_overflow | output | 1 | Push was dropped because the queue was full |
| lr_req | input | 1 | Request a link register write at the next commit |
| commit_start | input | 1 | Begin replaying the queue |
| seq_pc | input | ADDR_W | Next sequential packet address (saved PC) |
| exc_pending | input | 1 | Imprecise exception pending (sampled at commit_start) |
| exc_iaddr | input | ADDR_W | Excepting instruction address |
| exc_is_fp | input | 1 | Exception is floating-point |
| exc_fp_mask | input | FPM_W | Floating-point cause bits |
| commit_busy | output | 1 | Commit in progress |
| commit_done | output | 1 | Commit finished pulse |
| wr_en | output | 1 | Register write strobe |
| wr_target | output | TGT_W | Register write target |
| wr_value | output | DATA_W | Register write value |
| pc_out | output | ADDR_W | Visible PC |
| lr_wr_en | output | 1 | Link register write strobe |
| lr_value | output | ADDR_W | Link register value |

## Verification
The hardest situation to reach combines three things in one packet: an imprecise exception whose address matches some entries but not others, a PC write from the excepting instruction that is filtered away, and a later PC write that must still win. The stimulus draws issuing addresses from a pool of only four values and the exception address from the same pool, so matches happen often. Kinds, force flags and cause masks are randomized, and directed packets pin down the filtered-branch case, both sides of the floating-point cause rule, and a full queue.

// File: rtl/vcq_pkg.sv
// Shared types for the deferred write commit queue.
// Assumes: the kind field is two bits wide; code 3 is handled as a register write.
package vcq_pkg;
    typedef enum logic [1:0] {
        KIND_REG  = 2'd0,
        KIND_PC   = 2'd1,
        KIND_FNPC = 2'd2,
        KIND_RSV  = 2'd3
    } wkind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    // True for kinds that redirect the PC.
    function automatic logic is_pc_kind(input wkind_e k);
        return (k == KIND_PC) || (k == KIND_FNPC);
    endfunction
endpackage

// File: rtl/vcq_store.sv
// Entry storage with fill counter and overflow flag.
// Assumes: clear wins over a push in the same cycle; entries are written at index fill.
module vcq_store
    import vcq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TGT_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  wkind_e            push_kind,
    input  logic [TGT_W-1:0]  push_tgt,
    input  logic [DATA_W-1:0] push_val,
    input  logic [ADDR_W-1:0] push_ia,
    input  logic              push_frc,
    input  logic [IDX_W-1:0]  rd_idx,
    output wkind_e            rd_kind,
    output logic [TGT_W-1:0]  rd_tgt,
    output logic [DATA_W-1:0] rd_val,
    output logic [ADDR_W-1:0] rd_ia,
    output logic              rd_frc,
    output logic [CNT_W-1:0]  fill,
    output logic              overflow
);
    wkind_e            m_kind [DEPTH];
    logic [TGT_W-1:0]  m_tgt  [DEPTH];
    logic [DATA_W-1:0] m_val  [DEPTH];
    logic [ADDR_W-1:0] m_ia   [DEPTH];
    logic              m_frc  [DEPTH];

    logic has_room;
    assign has_room = (fill < CNT_W'(DEPTH));

    // Entry array write at the current fill position.
    always_ff @(posedge clk) begin
        if (push && has_room && !clr) begin
            m_kind[fill[IDX_W-1:0]] <= push_kind;
            m_tgt[fill[IDX_W-1:0]]  <= push_tgt;
            m_val[fill[IDX_W-1:0]]  <= push_val;
            m_ia[fill[IDX_W-1:0]]   <= push_ia;
            m_frc[fill[IDX_W-1:0]]  <= push_frc;
        end
    end

    // Fill count and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill     <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= push && !has_room && !clr;
            if (clr)
                fill <= '0;
            else if (push && has_room)
                fill <= fill + 1'b1;
        end
    end

    // Read port for the commit sequencer.
    always_comb begin
        rd_kind = m_kind[rd_idx];
        rd_tgt  = m_tgt[rd_idx];
        rd_val  = m_val[rd_idx];
        rd_ia   = m_ia[rd_idx];
        rd_frc  = m_frc[rd_idx];
    end
endmodule

// File: rtl/vcq_filter.sv
// Decides whether an entry executes under a pending imprecise exception.
// Assumes: cause bits [2:0] are the benign floating-point causes.
module vcq_filter #(
    parameter int ADDR_W = 32,
    parameter int FPM_W  = 6
) (
    input  logic              pend,
    input  logic [ADDR_W-1:0] exc_ia,
    input  logic              exc_fp,
    input  logic [FPM_W-1:0]  exc_mask,
    input  logic [ADDR_W-1:0] ent_ia,
    input  logic              ent_frc,
    output logic              keep
);
    localparam logic [FPM_W-1:0] FP_BENIGN = FPM_W'(3'b111);

    logic hit;
    // Keep decision: only entries from the excepting instruction are screened.
    always_comb begin
        hit = pend && (ent_ia == exc_ia);
        if (!hit)
            keep = 1'b1;
        else if (exc_fp)
            keep = ((exc_mask & ~FP_BENIGN) == '0);
        else
            keep = ent_frc;
    end
endmodule

// File: rtl/vcq_sequencer.sv
// Commit sequencer: replays entries one per clock, keeps the first branch,
// then sets the final PC, the link register and the done pulse.
// Assumes: commit_start is ignored while a commit runs.
module vcq_sequencer
    import vcq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TGT_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int FPM_W  = 6,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_start,
    input  logic [ADDR_W-1:0] seq_pc,
    input  logic              exc_pending,
    input  logic [ADDR_W-1:0] exc_iaddr,
    input  logic              exc_is_fp,
    input  logic [FPM_W-1:0]  exc_fp_mask,
    input  logic              lr_req,
    input  logic [CNT_W-1:0]  fill,
    input  wkind_e            rd_kind,
    input  logic [TGT_W-1:0]  rd_tgt,
    input  logic [DATA_W-1:0] rd_val,
    input  logic [ADDR_W-1:0] rd_ia,
    input  logic              keep,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              fin_clr,
    output logic              busy,
    output logic              cap_pend,
    output logic [ADDR_W-1:0] cap_ia,
    output logic              cap_fp,
    output logic [FPM_W-1:0]  cap_mask,
    output logic              wr_en,
    output logic [TGT_W-1:0]  wr_target,
    output logic [DATA_W-1:0] wr_value,
    output logic [ADDR_W-1:0] pc_out,
    output logic              lr_wr_en,
    output logic [ADDR_W-1:0] lr_value,
    output logic              done
);
    seq_state_e        st;
    logic [ADDR_W-1:0] saved_pc;
    logic [ADDR_W-1:0] br_tgt;
    logic              taken;
    logic              lr_flag;
    logic              last;

    assign busy    = (st != SEQ_IDLE);
    assign fin_clr = (st == SEQ_FIN);
    assign last    = ((CNT_W'(rd_idx) + 1'b1) == fill);

    // Commit state machine and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SEQ_IDLE;
            rd_idx    <= '0;
            saved_pc  <= '0;
            br_tgt    <= '0;
            taken     <= 1'b0;
            lr_flag   <= 1'b0;
            cap_pend  <= 1'b0;
            cap_ia    <= '0;
            cap_fp    <= 1'b0;
            cap_mask  <= '0;
            wr_en     <= 1'b0;
            wr_target <= '0;
            wr_value  <= '0;
            pc_out    <= '0;
            lr_wr_en  <= 1'b0;
            lr_value  <= '0;
            done      <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            lr_wr_en <= 1'b0;
            done     <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (commit_start) begin
                        saved_pc <= seq_pc;
                        cap_pend <= exc_pending;
                        cap_ia   <= exc_iaddr;
                        cap_fp   <= exc_is_fp;
                        cap_mask <= exc_fp_mask;
                        rd_idx   <= '0;
                        taken    <= 1'b0;
                        st       <= (fill == '0) ? SEQ_FIN : SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (keep) begin
                        if (is_pc_kind(rd_kind)) begin
                            if (!taken) begin
                                taken  <= 1'b1;
                                br_tgt <= ADDR_W'(rd_val);
                                pc_out <= rd_ia;
                            end
                        end else begin
                            wr_en     <= 1'b1;
                            wr_target <= rd_tgt;
                            wr_value  <= rd_val;
                            pc_out    <= rd_ia;
                        end
                    end
                    if (last)
                        st <= SEQ_FIN;
                    else
                        rd_idx <= rd_idx + 1'b1;
                end
                SEQ_FIN: begin
                    pc_out <= taken ? br_tgt : saved_pc;
                    if (lr_flag) begin
                        lr_wr_en <= 1'b1;
                        lr_value <= saved_pc;
                        lr_flag  <= 1'b0;
                    end
                    done <= 1'b1;
                    st   <= SEQ_IDLE;
                end
                default: st <= SEQ_IDLE;
            endcase
            if (lr_req)
                lr_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/vliw_commit_queue.sv
// Top: deferred write queue for one VLIW packet with ordered commit.
// Assumes: enqueues arrive only between pkt_start and commit_start.
module vliw_commit_queue
    import vcq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TGT_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int FPM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              enq_valid,
    input  logic [1:0]        enq_kind,
    input  logic [TGT_W-1:0]  enq_target,
    input  logic [DATA_W-1:0] enq_value,
    input  logic [ADDR_W-1:0] enq_iaddr,
    input  logic              enq_force,
    output logic              enq_overflow,
    input  logic              lr_req,
    input  logic              commit_start,
    input  logic [ADDR_W-1:0] seq_pc,
    input  logic              exc_pending,
    input  logic [ADDR_W-1:0] exc_iaddr,
    input  logic              exc_is_fp,
    input  logic [FPM_W-1:0]  exc_fp_mask,
    output logic              commit_busy,
    output logic              commit_done,
    output logic              wr_en,
    output logic [TGT_W-1:0]  wr_target,
    output logic [DATA_W-1:0] wr_value,
    output logic [ADDR_W-1:0] pc_out,
    output logic              lr_wr_en,
    output logic [ADDR_W-1:0] lr_value
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [CNT_W-1:0]  fill;
    logic [IDX_W-1:0]  rd_idx;
    wkind_e            rd_kind;
    logic [TGT_W-1:0]  rd_tgt;
    logic [DATA_W-1:0] rd_val;
    logic [ADDR_W-1:0] rd_ia;
    logic              rd_frc;
    logic              keep;
    logic              fin_clr;
    logic              cap_pend;
    logic [ADDR_W-1:0] cap_ia;
    logic              cap_fp;
    logic [FPM_W-1:0]  cap_mask;

    vcq_store #(
        .DEPTH(DEPTH), .TGT_W(TGT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pkt_start || fin_clr),
        .push     (enq_valid && !commit_busy),
        .push_kind(wkind_e'(enq_kind)),
        .push_tgt (enq_target),
        .push_val (enq_value),
        .push_ia  (enq_iaddr),
        .push_frc (enq_force),
        .rd_idx   (rd_idx),
        .rd_kind  (rd_kind),
        .rd_tgt   (rd_tgt),
        .rd_val   (rd_val),
        .rd_ia    (rd_ia),
        .rd_frc   (rd_frc),
        .fill     (fill),
        .overflow (enq_overflow)
    );

    vcq_filter #(.ADDR_W(ADDR_W), .FPM_W(FPM_W)) u_filter (
        .pend    (cap_pend),
        .exc_ia  (cap_ia),
        .exc_fp  (cap_fp),
        .exc_mask(cap_mask),
        .ent_ia  (rd_ia),
        .ent_frc (rd_frc),
        .keep    (keep)
    );

    vcq_sequencer #(
        .DEPTH(DEPTH), .TGT_W(TGT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .FPM_W(FPM_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_start(commit_start),
        .seq_pc      (seq_pc),
        .exc_pending (exc_pending),
        .exc_iaddr   (exc_iaddr),
        .exc_is_fp   (exc_is_fp),
        .exc_fp_mask (exc_fp_mask),
        .lr_req      (lr_req),
        .fill        (fill),
        .rd_kind     (rd_kind),
        .rd_tgt      (rd_tgt),
        .rd_val      (rd_val),
        .rd_ia       (rd_ia),
        .keep        (keep),
        .rd_idx      (rd_idx),
        .fin_clr     (fin_clr),
        .busy        (commit_busy),
        .cap_pend    (cap_pend),
        .cap_ia      (cap_ia),
        .cap_fp      (cap_fp),
        .cap_mask    (cap_mask),
        .wr_en       (wr_en),
        .wr_target   (wr_target),
        .wr_value    (wr_value),
        .pc_out      (pc_out),
        .lr_wr_en    (lr_wr_en),
        .lr_value    (lr_value),
        .done        (commit_done)
    );
endmodule

// File: rtl/vcq_checker.sv
// Temporal checks on the commit queue, bound to the top module.
// Assumes: fill is the top's internal entry count.
module vcq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] fill,
    input logic             pkt_start,
    input logic             commit_start,
    input logic             enq_overflow,
    input logic             commit_busy,
    input logic             commit_done,
    input logic             wr_en,
    input logic             lr_wr_en
);
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH)); // R3
    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        enq_overflow |-> $past(fill) == CNT_W'(DEPTH)); // R3
    AST_PKT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pkt_start) |-> fill == '0); // R4
    AST_WR_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(commit_busy)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> !commit_done); // R11
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (fill == '0) && !commit_busy); // R11
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_start && !commit_busy) |=> commit_busy); // R11
    AST_LR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        lr_wr_en |-> commit_done); // R10
endmodule

bind vliw_commit_queue vcq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_vcq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill        (fill),
    .pkt_start   (pkt_start),
    .commit_start(commit_start),
    .enq_overflow(enq_overflow),
    .commit_busy (commit_busy),
    .commit_done (commit_done),
    .wr_en       (wr_en),
    .lr_wr_en    (lr_wr_en)
);

// File: tb/vliw_commit_queue_test.sv
// Bench for the commit queue: seeded random packets plus directed corners,
// checked against a reference model written from the requirements.
module vliw_commit_queue_test;
    localparam int DEPTH = 16;
    localparam int TGT_W = 5;
    localparam int FPM_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start = 1'b0;
    logic        enq_valid = 1'b0;
    logic [1:0]  enq_kind = '0;
    logic [TGT_W-1:0] enq_target = '0;
    logic [31:0] enq_value = '0;
    logic [31:0] enq_iaddr = '0;
    logic        enq_force = 1'b0;
    logic        enq_overflow;
    logic        lr_req = 1'b0;
    logic        commit_start = 1'b0;
    logic [31:0] seq_pc = '0;
    logic        exc_pending = 1'b0;
    logic [31:0] exc_iaddr = '0;
    logic        exc_is_fp = 1'b0;
    logic [FPM_W-1:0] exc_fp_mask = '0;
    logic        commit_busy, commit_done, wr_en, lr_wr_en;
    logic [TGT_W-1:0] wr_target;
    logic [31:0] wr_value, pc_out, lr_value;

    vliw_commit_queue #(.DEPTH(DEPTH), .TGT_W(TGT_W), .DATA_W(32), .ADDR_W(32), .FPM_W(FPM_W)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .enq_valid(enq_valid),
        .enq_kind(enq_kind), .enq_target(enq_target), .enq_value(enq_value),
        .enq_iaddr(enq_iaddr), .enq_force(enq_force), .enq_overflow(enq_overflow),
        .lr_req(lr_req), .commit_start(commit_start), .seq_pc(seq_pc),
        .exc_pending(exc_pending), .exc_iaddr(exc_iaddr), .exc_is_fp(exc_is_fp),
        .exc_fp_mask(exc_fp_mask), .commit_busy(commit_busy), .commit_done(commit_done),
        .wr_en(wr_en), .wr_target(wr_target), .wr_value(wr_value), .pc_out(pc_out),
        .lr_wr_en(lr_wr_en), .lr_value(lr_value)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model of the queue contents.
    logic [1:0]  q_kind [DEPTH];
    logic [TGT_W-1:0] q_tgt [DEPTH];
    logic [31:0] q_val [DEPTH];
    logic [31:0] q_ia [DEPTH];
    logic        q_frc [DEPTH];
    int          nq = 0;
    bit          lr_pend = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Reference keep decision from R7, R8, R9.
    function automatic bit ref_keep(input int i);
        if (!exc_pending || q_ia[i] != exc_iaddr) return 1'b1;
        if (exc_is_fp) return (exc_fp_mask[FPM_W-1:3] == '0);
        return q_frc[i];
    endfunction

    task automatic pkt();
        @(negedge clk);
        pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        nq = 0;
    endtask

    task automatic enq(input logic [1:0] k, input logic [TGT_W-1:0] t, input logic [31:0] v,
                       input logic [31:0] ia, input bit f);
        bit full;
        full = (nq == DEPTH);
        enq_valid = 1'b1; enq_kind = k; enq_target = t; enq_value = v;
        enq_iaddr = ia; enq_force = f;
        @(negedge clk);
        enq_valid = 1'b0;
        chk(enq_overflow == full, full ? "R3 overflow on full" : "R3 no overflow",
            64'(enq_overflow), 64'(full));
        if (!full) begin
            q_kind[nq] = k; q_tgt[nq] = t; q_val[nq] = v; q_ia[nq] = ia; q_frc[nq] = f;
            nq++;
        end
    endtask

    task automatic req_link();
        lr_req = 1'b1;
        @(negedge clk);
        lr_req = 1'b0;
        lr_pend = 1'b1;
    endtask

    // Runs a commit and compares every write, the final PC and the link write.
    task automatic commit(input logic [31:0] spc);
        logic [TGT_W-1:0] e_t [DEPTH];
        logic [31:0] e_v [DEPTH];
        logic [31:0] e_ia [DEPTH];
        int ne = 0;
        int got = 0;
        int cyc = 0;
        bit tk = 1'b0;
        bit seen_done = 1'b0;
        logic [31:0] e_pc;
        e_pc = spc;
        for (int i = 0; i < nq; i++) begin
            if (ref_keep(i)) begin
                if (q_kind[i] == 2'd1 || q_kind[i] == 2'd2) begin
                    if (!tk) begin tk = 1'b1; e_pc = q_val[i]; end
                end else begin
                    e_t[ne] = q_tgt[i]; e_v[ne] = q_val[i]; e_ia[ne] = q_ia[i]; ne++;
                end
            end
        end
        seq_pc = spc;
        commit_start = 1'b1;
        @(negedge clk);
        commit_start = 1'b0;
        for (int c = 0; c < DEPTH + 4; c++) begin
            cyc = c + 1;
            if (wr_en) begin
                if (got < ne) begin
                    chk(wr_target == e_t[got] && wr_value == e_v[got], "R2 write order/data",
                        {27'd0, wr_target, wr_value}, {27'd0, e_t[got], e_v[got]});
                    chk(pc_out == e_ia[got], "R2 pc follows issuer", 64'(pc_out), 64'(e_ia[got]));
                end else begin
                    chk(1'b0, "R7 unexpected write", 64'(wr_value), 64'd0);
                end
                got++;
            end
            if (commit_done) begin seen_done = 1'b1; break; end
            @(negedge clk);
        end
        chk(seen_done && cyc == nq + 2, "R11 done timing", 64'(cyc), 64'(nq + 2));
        chk(got == ne, "R9 executed write count", 64'(got), 64'(ne));
        chk(pc_out == e_pc, tk ? "R5 first branch target" : "R6 sequential pc",
            64'(pc_out), 64'(e_pc));
        chk(lr_wr_en == lr_pend && (!lr_pend || lr_value == spc), "R10 link write",
            {31'd0, lr_wr_en, lr_value}, {31'd0, lr_pend, spc});
        lr_pend = 1'b0;
        nq = 0;
        @(negedge clk);
        chk(commit_done == 1'b0, "R11 done one cycle", 64'(commit_done), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        finish_up();
    end

    initial begin
        logic [31:0] pool [4];
        void'($urandom(32'd20240611));
        pool[0] = 32'h100; pool[1] = 32'h104; pool[2] = 32'h108; pool[3] = 32'h10C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!commit_busy && !commit_done && !wr_en && !lr_wr_en && !enq_overflow && pc_out == 0,
            "R1 reset outputs", {commit_busy, commit_done, wr_en, lr_wr_en, enq_overflow, pc_out},
            64'd0);
        commit(32'h2000); // R1 empty queue after reset

        // R2 plain in-order replay, including kind 3 as a register write
        pkt();
        enq(2'd0, 5'd1, 32'hA1, 32'h100, 1'b0);
        enq(2'd3, 5'd2, 32'hA2, 32'h104, 1'b0);
        enq(2'd0, 5'd3, 32'hA3, 32'h108, 1'b0);
        commit(32'h3000);

        // R3 overflow on a full queue
        pkt();
        for (int i = 0; i < DEPTH + 1; i++) enq(2'd0, 5'(i), 32'(i + 16), 32'h200 + 32'(i), 1'b0);
        commit(32'h3100);

        // R4 packet start empties queued writes
        pkt();
        enq(2'd0, 5'd4, 32'hB0, 32'h100, 1'b0);
        enq(2'd1, 5'd0, 32'h9000, 32'h104, 1'b0);
        pkt();
        commit(32'h3200);

        // R5 only the first branch is kept; R10 link request consumed
        pkt();
        req_link();
        enq(2'd1, 5'd0, 32'h8000, 32'h100, 1'b0);
        enq(2'd0, 5'd5, 32'hC0, 32'h104, 1'b0);
        enq(2'd2, 5'd0, 32'h8800, 32'h108, 1'b0);
        commit(32'h3300);
        pkt();
        commit(32'h3400); // R10 no link write without a new request

        // R12 filtered branch does not block a later one
        pkt();
        exc_pending = 1'b1; exc_iaddr = 32'h100; exc_is_fp = 1'b0;
        enq(2'd1, 5'd0, 32'h7000, 32'h100, 1'b0);
        enq(2'd0, 5'd6, 32'hD0, 32'h100, 1'b1);
        enq(2'd2, 5'd0, 32'h7100, 32'h104, 1'b0);
        commit(32'h3500);

        // R8 benign fp causes keep, other causes drop
        pkt();
        exc_is_fp = 1'b1; exc_fp_mask = 6'b000101;
        enq(2'd0, 5'd7, 32'hE0, 32'h100, 1'b0);
        commit(32'h3600);
        pkt();
        exc_fp_mask = 6'b001001;
        enq(2'd0, 5'd7, 32'hE1, 32'h100, 1'b0);
        enq(2'd0, 5'd8, 32'hE2, 32'h104, 1'b0);
        commit(32'h3700);

        // Random packets covering R2, R5 to R9, R12
        for (int p = 0; p < 60; p++) begin
            int n;
            pkt();
            n = int'($urandom_range(0, DEPTH));
            exc_pending = $urandom_range(0, 1) == 1;
            exc_iaddr = pool[$urandom_range(0, 3)];
            exc_is_fp = $urandom_range(0, 1) == 1;
            exc_fp_mask = ($urandom_range(0, 1) == 1) ? 6'($urandom_range(0, 7))
                                                      : 6'($urandom_range(0, 63));
            if ($urandom_range(0, 3) == 0) req_link();
            for (int i = 0; i < n; i++)
                enq(($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 2)) : 2'($urandom_range(0, 3) == 3 ? 3 : 0),
                    5'($urandom_range(0, 31)), $urandom, pool[$urandom_range(0, 3)],
                    $urandom_range(0, 1) == 1);
            commit($urandom);
        end
        finish_up();
    end
endmodule